// File: doc/BRIEF.md
# Register Bank with Direction-Controlled I/O Ports

This block is the register file of a small 8-bit processor datapath. Twenty-four general-purpose byte registers sit in one flat select space together with three I/O ports. Each port has a data byte and a direction byte. The datapath presents a select code, a write strobe and a write byte. A write lands on the rising clock edge. The byte at the selected location appears on the read bus combinationally, within the same cycle.

Each port drives its pins bit by bit. A pin whose direction bit is 1 is an output and carries the matching bit of the port data byte. A pin whose direction bit is 0 is released: its enable is low and its output value is held at 0. Pins are brought out as separate input, output and output-enable vectors, so that the pad ring can build the tristate buffers. A read of a port location merges the two sources: output pins return the data bit, and input pins return the live pin value.

Top module: `ioreg_bank`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, and every port output enable and pin output is 0.
- R2: Select codes 0 to 23 address general registers 0 to 23. A write with the strobe high is returned by later reads of the same code.
- R3: A write changes only the addressed location; every other location keeps its value.
- R4: Select codes 24, 25 and 26 address the data bytes of ports A, B and C. Port A uses pin bits 7:0, port B bits 15:8 and port C bits 23:16.
- R5: Select codes 27, 28 and 29 address the direction bytes of ports A, B and C. They read back as written.
- R6: Pin enable bit k of a port equals direction bit k. Pin output bit k equals data bit k when that direction bit is 1, and 0 when it is 0.
- R7: A read of a port data code returns, per bit, the data bit where the direction bit is 1 and the live pin input where it is 0.
- R8: Select codes 30 and 31 read as zero, and writes to them change no register and no pin.
- R9: With the write strobe low, no location changes, whatever the select and write data.
- R10: The read bus follows the select input within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 5 | Location select code |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte at the selected location |
| pin_in | input | 24 | Sampled pin values, ports A, B, C from bit 0 up |
| pin_out | output | 24 | Pin output values |
| pin_oe | output | 24 | Pin output enables, 1 = driven |

## Verification
The bench sweeps all 256 direction patterns on each port against varying data and pin bytes. A design that swaps the data and pin terms in the read merge, or drives released pins, shows up as a wrong read byte or a wrong pin vector. Every one of the 32 select codes is written and read back. This catches decoders that alias a port onto a neighbour, that let the unused codes 30 and 31 write or read non-zero, or that write with the strobe low. A second select change inside one clock phase exposes a read path that was registered by mistake.

// File: rtl/ioreg_pkg.sv
// Package ioreg_pkg
// Purpose : shared geometry constants of the register bank.
// Assumes : the select space holds the general registers first, then the
//           port data bytes, then the port direction bytes.
package ioreg_pkg;
    localparam int DEF_DATA_W    = 8;
    localparam int DEF_NUM_GP    = 24;
    localparam int DEF_NUM_PORTS = 3;
endpackage

// File: rtl/gp_reg_array.sv
// Module gp_reg_array
// Purpose : holds the general-purpose byte registers and writes the one
//           addressed by sel when wr_en is high.
// Assumes : general registers occupy select codes 0 .. NUM_GP-1.
module gp_reg_array #(
    parameter int DATA_W = 8,
    parameter int NUM_GP = 24,
    parameter int SEL_W  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SEL_W-1:0]              sel,
    input  logic                          wr_en,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_GP-1:0][DATA_W-1:0] regs_q
);

    for (genvar g = 0; g < NUM_GP; g++) begin : g_reg
        logic hit;
        assign hit = wr_en && (sel == SEL_W'(g));

        // Capture write data into this register on a select hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (hit) begin
                regs_q[g] <= wr_data;
            end
        end
    end

    // R1: all registers are clear on the first cycle out of reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs_q == '0));

    // R2: an enabled write to a general code lands in that register
    a_r2_gp_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel < SEL_W'(NUM_GP))) |=> (regs_q[$past(sel)] == $past(wr_data)));

    // R9: nothing changes while the strobe is low
    a_r9_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/io_port_slice.sv
// Module io_port_slice
// Purpose : one I/O port, with a data byte, a direction byte, the pin
//           drive and the merged read value.
// Assumes : direction bit 1 = output; released pins output 0 with enable 0.
module io_port_slice #(
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 5,
    parameter int DATA_SEL = 24,
    parameter int DIR_SEL  = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] port_rd,
    output logic [DATA_W-1:0] dir_rd
);

    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] dir_q;

    // Port data byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_en && (sel == SEL_W'(DATA_SEL))) begin
            data_q <= wr_data;
        end
    end

    // Port direction byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_en && (sel == SEL_W'(DIR_SEL))) begin
            dir_q <= wr_data;
        end
    end

    // Pin drive and per-bit read merge.
    always_comb begin
        pin_oe  = dir_q;
        pin_out = data_q & dir_q;
        port_rd = (data_q & dir_q) | (pin_in & ~dir_q);
        dir_rd  = dir_q;
    end

    // R5: a direction write shows up on the pin enables next cycle
    a_r5_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_W'(DIR_SEL))) |=> (pin_oe == $past(wr_data)));

    // R7: with every pin released, a port read returns the pins
    a_r7_all_input_read: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == '0) |-> (port_rd == pin_in));

endmodule

// File: rtl/read_select.sv
// Module read_select
// Purpose : combinational decoder placing the selected location on rd_data.
// Assumes : codes past the last direction byte read as zero.
module read_select #(
    parameter int DATA_W    = 8,
    parameter int NUM_GP    = 24,
    parameter int NUM_PORTS = 3,
    parameter int SEL_W     = 5
) (
    input  logic [SEL_W-1:0]                 sel,
    input  logic [NUM_GP-1:0][DATA_W-1:0]    gp_regs,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] port_rd,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] dir_rd,
    output logic [DATA_W-1:0]                rd_data
);

    // Pick the one location whose code matches sel.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_GP; i++) begin
            if (sel == SEL_W'(i)) rd_data = gp_regs[i];
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (sel == SEL_W'(NUM_GP + p)) rd_data = port_rd[p];
            if (sel == SEL_W'(NUM_GP + NUM_PORTS + p)) rd_data = dir_rd[p];
        end
    end

endmodule

// File: rtl/ioreg_bank.sv
// Module ioreg_bank
// Purpose : top of the register bank, joining the general registers, the
//           port slices and the read decoder in one select space.
// Assumes : synchronous active-low reset; pins split into in/out/enable.
module ioreg_bank
    import ioreg_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int NUM_GP    = DEF_NUM_GP,
    parameter int NUM_PORTS = DEF_NUM_PORTS,
    localparam int TOTAL    = NUM_GP + 2 * NUM_PORTS,
    localparam int SEL_W    = $clog2(TOTAL),
    localparam int PIN_W    = NUM_PORTS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);

    logic [NUM_GP-1:0][DATA_W-1:0]    gp_regs;
    logic [NUM_PORTS-1:0][DATA_W-1:0] port_rd;
    logic [NUM_PORTS-1:0][DATA_W-1:0] dir_rd;

    gp_reg_array #(
        .DATA_W (DATA_W),
        .NUM_GP (NUM_GP),
        .SEL_W  (SEL_W)
    ) gp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .regs_q  (gp_regs)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        io_port_slice #(
            .DATA_W   (DATA_W),
            .SEL_W    (SEL_W),
            .DATA_SEL (NUM_GP + p),
            .DIR_SEL  (NUM_GP + NUM_PORTS + p)
        ) port_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel),
            .wr_en   (wr_en),
            .wr_data (wr_data),
            .pin_in  (pin_in[p*DATA_W +: DATA_W]),
            .pin_out (pin_out[p*DATA_W +: DATA_W]),
            .pin_oe  (pin_oe[p*DATA_W +: DATA_W]),
            .port_rd (port_rd[p]),
            .dir_rd  (dir_rd[p])
        );
    end

    read_select #(
        .DATA_W    (DATA_W),
        .NUM_GP    (NUM_GP),
        .NUM_PORTS (NUM_PORTS),
        .SEL_W     (SEL_W)
    ) rd_i (
        .sel     (sel),
        .gp_regs (gp_regs),
        .port_rd (port_rd),
        .dir_rd  (dir_rd),
        .rd_data (rd_data)
    );

    // R8: unused codes read as zero
    a_r8_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel >= SEL_W'(TOTAL)) |-> (rd_data == '0));

    // R8: writes to unused codes leave the pins untouched
    a_r8_unused_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel >= SEL_W'(TOTAL))) |=> ($stable(pin_oe) && $stable(pin_out)));

    // R6: a released pin never carries a driven 1
    a_r6_released_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

endmodule

// File: tb/ioreg_bank_tb_top.sv
module ioreg_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  sel = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] model [0:31];

    always #5 clk = ~clk;

    ioreg_bank dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input int s, input logic [7:0] v);
        @(negedge clk);
        sel = 5'(s); wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int s);
        return 8'((s * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] pin_byte(input int p);
        return pin_in[p*8 +: 8];
    endfunction

    // Expected read for any code from the bench model and current pins.
    function automatic logic [7:0] expect_rd(input int s);
        if (s < 24) return model[s];
        if (s < 27) return (model[s] & model[s+3]) | (pin_byte(s-24) & ~model[s+3]);
        if (s < 30) return model[s];
        return 8'h00;
    endfunction

    task automatic read_all(input string req);
        for (int s = 0; s < 32; s++) begin
            @(negedge clk);
            sel = 5'(s);
            #1;
            chk(req, 32'(rd_data), 32'(expect_rd(s)));
        end
    endtask

    initial begin
        for (int s = 0; s < 32; s++) model[s] = 8'h00;
        pin_in = 24'h5A3C96;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R7 released pins read back, R8 unused codes zero
        read_all("R1");
        chk("R1 pin_oe", 32'(pin_oe), 32'h0);
        chk("R1 pin_out", 32'(pin_out), 32'h0);

        // R2 R4 R5 R8: write every code, then read all back (R3 isolation)
        for (int s = 0; s < 32; s++) begin
            do_write(s, pat(s));
            if (s < 30) model[s] = pat(s);
        end
        read_all("R3");
        for (int p = 0; p < 3; p++) begin
            chk("R6 oe", 32'(pin_oe[p*8 +: 8]), 32'(model[27+p]));
            chk("R6 out", 32'(pin_out[p*8 +: 8]), 32'(model[24+p] & model[27+p]));
        end

        // R9: strobe low on every code with inverted data
        for (int s = 0; s < 32; s++) begin
            @(negedge clk);
            sel = 5'(s); wr_data = ~pat(s); wr_en = 1'b0;
        end
        read_all("R9");

        // R3: one targeted write, everything else unchanged
        do_write(12, 8'hC3);
        model[12] = 8'hC3;
        read_all("R3");

        // R8: writes to codes 30 and 31 leave pins and registers alone
        do_write(30, 8'hFF);
        do_write(31, 8'hFF);
        chk("R8 oe", 32'(pin_oe), {8'h0, model[29], model[28], model[27]});
        read_all("R8");

        // R10: two select changes within one low phase
        @(negedge clk);
        sel = 5'd3; #1;
        chk("R10", 32'(rd_data), 32'(model[3]));
        sel = 5'd12; #1;
        chk("R10", 32'(rd_data), 32'hC3);

        // R4 R5 R6 R7: full direction sweep per port
        for (int p = 0; p < 3; p++) begin
            for (int d = 0; d < 256; d++) begin
                logic [7:0] dv, dat, pv;
                dv  = 8'(d);
                dat = dv ^ 8'h5A;
                pv  = 8'((d * 5 + 3) & 255);
                pin_in[p*8 +: 8] = pv;
                do_write(27 + p, dv);
                do_write(24 + p, dat);
                model[27+p] = dv;
                model[24+p] = dat;
                #1;
                sel = 5'(24 + p); #1;
                chk("R7 merge", 32'(rd_data), 32'((dat & dv) | (pv & ~dv)));
                sel = 5'(27 + p); #1;
                chk("R5 dir", 32'(rd_data), 32'(dv));
                chk("R6 oe", 32'(pin_oe[p*8 +: 8]), 32'(dv));
                chk("R6 out", 32'(pin_out[p*8 +: 8]), 32'(dat & dv));
            end
        end
        read_all("R4");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule